// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block lets a clocked host reach an external static RAM that has no clock of its own: 2^18 words of 16 bits, with one active-low enable for each byte lane. The host presents a one-cycle request made of a word address, a direction flag, write data and a lane mask. The controller then drives the memory's active-low chip select, write strobe, output enable and lane enables from registers, so none of them glitches. When the access finishes, it returns a one-cycle completion pulse, together with the read data for a read.

All memory timing comes from whole clock counts. Each count is derived at elaboration by rounding a nanosecond limit up to clock periods. During a write, output enable stays high for the whole strobe, so the shorter strobe limit applies. The controller drives the shared data bus only after the memory has had one full cycle to release it, and stops driving the moment the strobe ends. When the direction changes from read to write or from write to read, extra deselected cycles are inserted first. A request whose lane mask is empty finishes without touching the memory.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, and whenever no access is running, memCeN, memWeN, memOeN and both memByteN bits are 1, memDrive is 0, rspDone is 0 and hostReady is 1.
- R2: A read with a non-empty mask holds memCeN=0, memOeN=0 and memWeN=1 for exactly RD_CYC consecutive cycles, where RD_CYC = ceil(ACC_NS/CLK_NS) and is at least 1.
- R3: Read data is sampled from memDin at the end of the last read cycle and is presented on rspRdata while rspDone is high. Mask bit 0 selects bits 7:0 and mask bit 1 selects bits 15:8. The bits of a lane that is not selected read as 0.
- R4: A write with a non-empty mask holds memCeN=0, memWeN=0 and memOeN=1 for exactly WR_CYC consecutive cycles, where WR_CYC = max(ceil(WP_NS/CLK_NS), ceil(DV_NS/CLK_NS)+1).
- R5: memDrive is 1 only while memWeN is 0, never in the first strobe cycle, and never while memOeN is 0. A write drives for exactly WR_CYC-1 cycles, and memDout carries the request's write data during that time.
- R6: While memCeN is 0, memByteN[0] = ~mask[0] and memByteN[1] = ~mask[1]. While memCeN is 1, both bits are 1.
- R7: A write changes only the lanes selected by its mask. This is judged by reading the word back.
- R8: When an access has a different direction from the last non-empty access, TURN_CYC deselected cycles come before it. After reset the last direction counts as read. An access in the same direction gets no extra cycles.
- R9: rspDone is high for exactly one cycle. That cycle falls RD_CYC or WR_CYC cycles (plus any turnaround) after the accepting edge. hostReady is 0 from the accepting edge until the cycle after rspDone. A request presented while hostReady is 0 is ignored.
- R10: A request with mask 0 asserts no memory strobe, raises rspDone in the cycle right after acceptance, and does not change the remembered direction.
- R11: memAddr equals the accepted request address for the whole access, even if reqAddr changes meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe, taken when hostReady is 1 |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 18 | Word address |
| reqWdata | input | 16 | Write data |
| reqMask | input | 2 | Lane select, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| hostReady | output | 1 | Controller can accept a request this cycle |
| rspDone | output | 1 | One-cycle completion pulse |
| rspRdata | output | 16 | Read data, unselected lanes zero |
| memCeN | output | 1 | Chip select, active low |
| memWeN | output | 1 | Write strobe, active low |
| memOeN | output | 1 | Output enable, active low |
| memByteN | output | 2 | Lane enables, active low, bit 0 = lower byte |
| memAddr | output | 18 | Memory address |
| memDout | output | 16 | Data toward memory |
| memDrive | output | 1 | Enables the bus driver for memDout |
| memDin | input | 16 | Data from memory |

## Verification
Two things can fall in the same cycle: a host request arriving, and an access that is already walking its read-wait count. The bench provokes this by presenting a full-mask write to a second address in the middle of a read, with a changed address on reqAddr. It then judges that the read's latency, its held memAddr and its data are untouched, and that a later read-back of the second address still shows the old contents. The other overlap is between the turnaround decision and the acceptance of an access. A sweep over every write mask followed by every read mask mixes same-direction and opposite-direction pairs, as well as empty-mask requests that must not disturb the remembered direction. Each latency is compared with the count worked out from the nanosecond figures.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TURN  = 2'd1,
    ST_READ  = 2'd2,
    ST_WRITE = 2'd3
  } ctrl_state_e;

  // Strobes from control to datapath, decoded from the next state
  typedef struct packed {
    logic load;     // capture the host request this edge
    logic sel;      // chip selected next cycle
    logic rd;       // read phase next cycle
    logic wr;       // write strobe next cycle
    logic drive;    // bus driven next cycle
    logic capture;  // sample memDin this edge
  } strobe_t;

  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC   = 1,
  parameter int WR_CYC   = 2,
  parameter int TURN_CYC = 1,
  parameter int CNT_W    = 2,
  parameter int LANES    = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [LANES-1:0] reqMask,
  output logic             hostReady,
  output logic             rspDone,
  output strobe_t          strb
);

  localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LD   = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LD = CNT_W'((TURN_CYC > 0) ? TURN_CYC - 1 : 0);

  ctrl_state_e      state, stateN;
  logic [CNT_W-1:0] cnt, cntN;
  logic             lastWr, lastWrN;
  logic             pendWr, pendWrN;
  logic             doneN;
  logic             accept;

  assign hostReady = (state == ST_IDLE) && !rspDone;
  assign accept    = hostReady && reqValid;

  always_comb begin
    stateN  = state;
    cntN    = cnt;
    lastWrN = lastWr;
    pendWrN = pendWr;
    doneN   = 1'b0;
    strb    = '0;
    case (state)
      ST_IDLE: begin
        if (accept) begin
          strb.load = 1'b1;
          pendWrN   = reqWrite;
          if (reqMask == '0) begin
            doneN = 1'b1;
          end else if ((reqWrite != lastWr) && (TURN_CYC > 0)) begin
            stateN = ST_TURN;
            cntN   = TURN_LD;
          end else begin
            stateN  = reqWrite ? ST_WRITE : ST_READ;
            cntN    = reqWrite ? WR_LD : RD_LD;
            lastWrN = reqWrite;
          end
        end
      end
      ST_TURN: begin
        if (cnt == '0) begin
          stateN  = pendWr ? ST_WRITE : ST_READ;
          cntN    = pendWr ? WR_LD : RD_LD;
          lastWrN = pendWr;
        end else begin
          cntN = cnt - 1'b1;
        end
      end
      ST_READ: begin
        if (cnt == '0) begin
          stateN       = ST_IDLE;
          doneN        = 1'b1;
          strb.capture = 1'b1;
        end else begin
          cntN = cnt - 1'b1;
        end
      end
      ST_WRITE: begin
        if (cnt == '0) begin
          stateN = ST_IDLE;
          doneN  = 1'b1;
        end else begin
          cntN = cnt - 1'b1;
        end
      end
      default: stateN = ST_IDLE;
    endcase
    strb.rd    = (stateN == ST_READ);
    strb.wr    = (stateN == ST_WRITE);
    strb.sel   = strb.rd || strb.wr;
    // bus is taken only in strobe cycles after the first one
    strb.drive = (stateN == ST_WRITE) && (state == ST_WRITE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      lastWr  <= 1'b0;
      pendWr  <= 1'b0;
      rspDone <= 1'b0;
    end else begin
      state   <= stateN;
      cnt     <= cntN;
      lastWr  <= lastWrN;
      pendWr  <= pendWrN;
      rspDone <= doneN;
    end
  end

  // R9: completion is a single-cycle pulse
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

  // R10: an empty mask completes at once and stays idle
  a_r10_empty_mask: assert property (@(posedge clk) disable iff (!rstN)
    (accept && (reqMask == '0)) |=> (rspDone && state == ST_IDLE));

  // R8: a turnaround always leads into an access
  a_r8_turn_exit: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TURN && cnt == '0) |=> (state == ST_READ || state == ST_WRITE));

endmodule

// File: rtl/sram_ctrl_dpath.sv
module sram_ctrl_dpath
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqMask,
  input  logic [DATA_W-1:0] memDin,
  output logic [DATA_W-1:0] rspRdata,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [LANES-1:0]  memByteN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic              memDrive
);

  localparam int LANE_W = DATA_W / LANES;

  logic [LANES-1:0]  maskQ;
  logic [LANES-1:0]  maskN;
  logic [DATA_W-1:0] laneBits;

  assign maskN = strb.load ? reqMask : maskQ;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign laneBits[g*LANE_W +: LANE_W] = {LANE_W{maskQ[g]}};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ    <= '0;
      memAddr  <= '0;
      memDout  <= '0;
      rspRdata <= '0;
      memCeN   <= 1'b1;
      memWeN   <= 1'b1;
      memOeN   <= 1'b1;
      memByteN <= '1;
      memDrive <= 1'b0;
    end else begin
      if (strb.load) begin
        maskQ   <= reqMask;
        memAddr <= reqAddr;
        memDout <= reqWdata;
      end
      if (strb.capture) begin
        rspRdata <= memDin & laneBits;
      end
      memCeN   <= !strb.sel;
      memWeN   <= !strb.wr;
      memOeN   <= !strb.rd;
      memByteN <= ~(maskN & {LANES{strb.sel}});
      memDrive <= strb.drive;
    end
  end

  // R5: bus only driven inside the strobe
  a_r5_drive_in_strobe: assert property (@(posedge clk) disable iff (!rstN)
    memDrive |-> !memWeN);

  // R5: never drive while the memory may be driving for a read
  a_r5_no_drive_oe: assert property (@(posedge clk) disable iff (!rstN)
    memDrive |-> memOeN);

  // R5: first strobe cycle leaves the bus free
  a_r5_first_cycle_free: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memWeN) |-> !memDrive);

  // R4: output enable stays off and chip selected during a write strobe
  a_r4_oe_off_write: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (memOeN && !memCeN));

  // R2: output enable only in a selected read
  a_r2_oe_in_read: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> (memWeN && !memCeN));

  // R6: lane enables off while deselected
  a_r6_lanes_desel: assert property (@(posedge clk) disable iff (!rstN)
    memCeN |-> (memByteN == '1));

  // R11: address stable through a selected stretch
  a_r11_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && !$past(memCeN)) |-> $stable(memAddr));

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 16,
  parameter int CLK_NS   = 20,
  parameter int ACC_NS   = 12,
  parameter int WP_NS    = 9,
  parameter int DV_NS    = 6,
  parameter int TURN_CYC = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [1:0]        reqMask,
  output logic              hostReady,
  output logic              rspDone,
  output logic [DATA_W-1:0] rspRdata,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [1:0]        memByteN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic              memDrive,
  input  logic [DATA_W-1:0] memDin
);

  localparam int LANES  = 2;
  localparam int RD_CYC = imax(1, cdiv(ACC_NS, CLK_NS));
  localparam int WR_CYC = imax(cdiv(WP_NS, CLK_NS), cdiv(DV_NS, CLK_NS) + 1);
  localparam int MAXC   = imax(imax(RD_CYC, WR_CYC), TURN_CYC);
  localparam int CNT_W  = imax(1, $clog2(MAXC + 1));

  strobe_t strb;

  sram_ctrl_fsm #(
    .RD_CYC  (RD_CYC),
    .WR_CYC  (WR_CYC),
    .TURN_CYC(TURN_CYC),
    .CNT_W   (CNT_W),
    .LANES   (LANES)
  ) u_fsm (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqMask  (reqMask),
    .hostReady(hostReady),
    .rspDone  (rspDone),
    .strb     (strb)
  );

  sram_ctrl_dpath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LANES (LANES)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .reqMask (reqMask),
    .memDin  (memDin),
    .rspRdata(rspRdata),
    .memCeN  (memCeN),
    .memWeN  (memWeN),
    .memOeN  (memOeN),
    .memByteN(memByteN),
    .memAddr (memAddr),
    .memDout (memDout),
    .memDrive(memDrive)
  );

endmodule

// File: tb/tb_sram_lane_ctrl.sv
module tb_sram_lane_ctrl;

  localparam int CLKP   = 20;
  localparam int ACC    = 50;
  localparam int WP     = 30;
  localparam int DV     = 25;
  localparam int TURN   = 2;
  localparam int RDE    = (ACC + CLKP - 1) / CLKP;
  localparam int WRA    = (WP + CLKP - 1) / CLKP;
  localparam int WRB    = (DV + CLKP - 1) / CLKP + 1;
  localparam int WRE    = (WRA > WRB) ? WRA : WRB;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [17:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqMask = '0;
  logic hostReady, rspDone, memCeN, memWeN, memOeN, memDrive;
  logic [15:0] rspRdata, memDout, memDin;
  logic [1:0]  memByteN;
  logic [17:0] memAddr;

  int checks = 0;
  int fails  = 0;
  bit lastDirWr = 1'b0;

  logic [15:0] mem    [256];
  logic [15:0] refMem [256];

  always #(CLKP/2) clk = ~clk;

  sram_lane_ctrl #(
    .CLK_NS(CLKP), .ACC_NS(ACC), .WP_NS(WP), .DV_NS(DV), .TURN_CYC(TURN)
  ) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .hostReady(hostReady), .rspDone(rspDone), .rspRdata(rspRdata),
    .memCeN(memCeN), .memWeN(memWeN), .memOeN(memOeN), .memByteN(memByteN),
    .memAddr(memAddr), .memDout(memDout), .memDrive(memDrive), .memDin(memDin)
  );

  // memory model: unselected lanes return junk the controller must mask
  always_comb begin
    if (!memCeN && !memOeN && memWeN)
      memDin = {memByteN[1] ? 8'hEE : mem[memAddr[7:0]][15:8],
                memByteN[0] ? 8'hEE : mem[memAddr[7:0]][7:0]};
    else
      memDin = 16'hBEEF;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (!memCeN && !memWeN && memDrive) begin
        if (!memByteN[0]) mem[memAddr[7:0]][7:0]  = memDout[7:0];
        if (!memByteN[1]) mem[memAddr[7:0]][15:8] = memDout[15:8];
      end
      if (memDrive && !memOeN) chk(1'b0, "R5 drive against read", 1, 0);
      if (memDrive && memWeN)  chk(1'b0, "R5 drive outside strobe", 1, 0);
    end
  end

  task automatic access(input bit wr, input logic [17:0] a, input logic [15:0] d,
                        input logic [1:0] m, input bit poke);
    int lat = 0, ceCnt = 0, weCnt = 0, oeCnt = 0, drvCnt = 0;
    int expTurn, expLat, expAcc;
    logic [15:0] expData, laneM;
    @(negedge clk);
    while (!hostReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; reqMask = m;
    @(negedge clk);
    reqValid = 1'b0;
    forever begin
      if (poke && lat == 1) begin
        reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 18'h00077;
        reqWdata = 16'h0000; reqMask = 2'b11;
      end else if (poke && lat == 2) begin
        reqValid = 1'b0;
      end
      if (!memCeN) begin
        ceCnt++;
        chk(memAddr == a, "R11 address held", memAddr, a);
        chk(memByteN == ~m, "R6 lane enables", memByteN, ~m);
      end else begin
        chk(memByteN == 2'b11, "R6 lanes off when deselected", memByteN, 2'b11);
      end
      if (!memWeN) begin
        weCnt++;
        chk(memOeN == 1'b1, "R4 oe high in write", memOeN, 1);
        if (memDrive) chk(memDout == d, "R5 write data on bus", memDout, d);
      end
      if (!memOeN) oeCnt++;
      if (memDrive) drvCnt++;
      if (rspDone || lat > 60) break;
      if (lat > 0) chk(!hostReady, "R9 not ready while busy", hostReady, 0);
      lat++;
      @(negedge clk);
    end
    reqValid = 1'b0;
    expTurn = (m != 0 && wr != lastDirWr) ? TURN : 0;
    expAcc  = (m == 0) ? 0 : (wr ? WRE : RDE);
    expLat  = expTurn + expAcc;
    if (m == 0) chk(lat == 0, "R10 empty mask done at once", lat, 0);
    else chk(lat == expLat, wr ? "R8 R9 write latency" : "R8 R9 read latency", lat, expLat);
    chk(ceCnt == expAcc, "R2 R4 select length", ceCnt, expAcc);
    chk(weCnt == ((wr && m != 0) ? WRE : 0), "R4 strobe length", weCnt, (wr && m != 0) ? WRE : 0);
    chk(oeCnt == ((!wr && m != 0) ? RDE : 0), "R2 read enable length", oeCnt, (!wr && m != 0) ? RDE : 0);
    chk(drvCnt == ((wr && m != 0) ? WRE - 1 : 0), "R5 drive length", drvCnt, (wr && m != 0) ? WRE - 1 : 0);
    laneM = {{8{m[1]}}, {8{m[0]}}};
    if (!wr && m != 0) begin
      expData = refMem[a[7:0]] & laneM;
      chk(rspRdata == expData, "R3 R7 read data", rspRdata, expData);
    end
    if (wr) refMem[a[7:0]] = (refMem[a[7:0]] & ~laneM) | (d & laneM);
    if (m != 0) lastDirWr = wr;
    @(negedge clk);
    chk(!rspDone, "R9 done one cycle", rspDone, 0);
    chk(memCeN && memWeN && memOeN && !memDrive, "R1 idle pins", {memCeN, memWeN, memOeN, memDrive}, 4'b1110);
  endtask

  initial begin
    #(CLKP * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [17:0] addrs [4];
    addrs[0] = 18'h00000; addrs[1] = 18'h00001; addrs[2] = 18'h3FFFF; addrs[3] = 18'h2AA55;
    for (int i = 0; i < 256; i++) begin
      mem[i]    = 16'(i * 16'h0101) ^ 16'h5A3C;
      refMem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    chk(memCeN && memWeN && memOeN && memByteN == 2'b11 && !memDrive && !rspDone,
        "R1 pins in reset", {memCeN, memWeN, memOeN, memByteN, memDrive, rspDone}, 7'b1111100);
    rstN = 1'b1;
    @(negedge clk);
    chk(hostReady == 1'b1, "R1 ready after reset", hostReady, 1);
    // first access is a read: no turnaround from reset state (R8)
    access(1'b0, addrs[0], 16'h0, 2'b11, 1'b0);
    // a write after a write: no turnaround (R8)
    access(1'b1, 18'h00010, 16'h1234, 2'b11, 1'b0);
    access(1'b1, 18'h00011, 16'h5678, 2'b11, 1'b0);
    // request ignored during busy read (R9)
    access(1'b0, 18'h00010, 16'h0, 2'b11, 1'b1);
    access(1'b0, 18'h00077, 16'h0, 2'b11, 1'b0);
    // sweep every write mask against every read mask (R3 R6 R7 R10)
    foreach (addrs[ai]) begin
      for (int wm = 0; wm < 4; wm++) begin
        access(1'b1, addrs[ai], 16'(16'hC3A1 + wm * 16'h1111 + ai * 16'h0F0F), 2'(wm), 1'b0);
        for (int rm = 0; rm < 4; rm++)
          access(1'b0, addrs[ai], 16'h0, 2'(rm), 1'b0);
      end
    end
    // empty-mask write between reads keeps the read direction (R10)
    access(1'b0, addrs[1], 16'h0, 2'b01, 1'b0);
    access(1'b1, addrs[1], 16'hFFFF, 2'b00, 1'b0);
    access(1'b0, addrs[1], 16'h0, 2'b11, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule